// File: doc/BRIEF.md
# Parallel Video to AXI4-Stream Bridge

This block takes a free-running parallel pixel stream (pixel word, data-enable, horizontal sync, vertical sync) and turns it into an AXI4-Stream video master. Only pixels that arrive with data-enable high are forwarded. Blanking is discarded. The stream carries two sideband flags: `m_tuser` marks the first pixel of each frame and `m_tlast` marks the last pixel of each line. Both flags are derived from the sync and enable timing.

Each colour component is placed in its own lane. The lane width is the component width rounded up to a whole number of bytes, and the unused upper bits of each lane are zero. The video source cannot be stalled, so a small FIFO absorbs short bursts of downstream backpressure. A pixel that finds the FIFO full is dropped, and a sticky flag records the loss. Everything runs on one clock, qualified by a clock enable, and the block has an asynchronous active-low reset.

Top module: `vid2axis_bridge`

## Requirements
- R1: A beat leaves the bridge only on a rising edge where `m_tvalid`, `m_tready`, `ce` and `rst_n` are all high. On any other edge the head beat stays offered.
- R2: Only pixels sampled with `vid_de` high on an enabled cycle are sent, in arrival order. Cycles with `vid_de` low produce no beat.
- R3: `m_tuser` is high on exactly one beat per frame. That beat is the first enabled `vid_de` pixel after a rising edge of `vid_vs` (active high), however many blank cycles lie between the edge and the pixel.
- R4: `m_tlast` is high on a pixel when the next enabled cycle has `vid_de` low or `vid_hs` high. It is low on every other pixel.
- R5: Component k of `vid_pix` (bits [k*COMP_W +: COMP_W]) appears at `m_tdata` bits [k*LANE_W +: COMP_W]. LANE_W is COMP_W rounded up to a multiple of 8, and the remaining lane bits are zero.
- R6: While `m_tvalid` is high and the beat is not taken, `m_tvalid`, `m_tdata`, `m_tuser` and `m_tlast` stay unchanged.
- R7: The FIFO holds at most FIFO_DEPTH pixels. A pixel pushed while the FIFO is full and no beat leaves is dropped, and `overflow` goes high and stays high until reset.
- R8: While `ce` is low, all inputs are ignored and no internal state changes, including the sync edge detector.
- R9: While `rst_n` is low, the FIFO empties, `m_tvalid` and `overflow` are low, and any pending start-of-frame is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable qualifying every state change |
| vid_pix | input | NUM_COMP*COMP_W | Parallel pixel word, component k in bits [k*COMP_W +: COMP_W] |
| vid_de | input | 1 | Data-enable, high for active pixels |
| vid_hs | input | 1 | Horizontal sync, active high |
| vid_vs | input | 1 | Vertical sync, active high |
| m_tdata | output | NUM_COMP*LANE_W | Padded pixel data |
| m_tvalid | output | 1 | Beat available |
| m_tready | input | 1 | Sink accepts beat |
| m_tuser | output | 1 | Start-of-frame flag |
| m_tlast | output | 1 | End-of-line flag |
| overflow | output | 1 | Sticky pixel-drop indicator |

## Verification
The bench builds the bridge with 10-bit components, three of them, and a FIFO depth of 4. The 10-bit width makes every lane carry six zero pad bits, so R5 is checked on every beat. The shallow FIFO lets a single seven-pixel line against a stalled sink reach the full and drop condition within a few cycles. Random frames with short lines stay within that depth, because the sink is kept ready through most of the blanking. Directed cases cover a mid-line horizontal sync, a reset that cancels a pending frame start, and overflow stickiness.

// File: rtl/vid2axis_bridge.sv
module vid2axis_bridge #(
  parameter int COMP_W     = 10,
  parameter int NUM_COMP   = 3,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   ce,
  input  logic [NUM_COMP*COMP_W-1:0]             vid_pix,
  input  logic                                   vid_de,
  input  logic                                   vid_hs,
  input  logic                                   vid_vs,
  output logic [NUM_COMP*(((COMP_W+7)/8)*8)-1:0] m_tdata,
  output logic                                   m_tvalid,
  input  logic                                   m_tready,
  output logic                                   m_tuser,
  output logic                                   m_tlast,
  output logic                                   overflow
);
  localparam int LANE_W = ((COMP_W + 7) / 8) * 8;
  localparam int OUT_W  = NUM_COMP * LANE_W;
  localparam int ENT_W  = OUT_W + 2;
  localparam int PTR_W  = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);

  logic [OUT_W-1:0] pix_pad;
  for (genvar g = 0; g < NUM_COMP; g++) begin : g_lane
    assign pix_pad[g*LANE_W +: LANE_W] = LANE_W'(vid_pix[g*COMP_W +: COMP_W]);
  end

  logic             vs_q, sof_armed;
  logic             hold_vld, hold_sof;
  logic [OUT_W-1:0] hold_pix;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic [ENT_W-1:0] mem [FIFO_DEPTH];

  wire vs_edge  = vid_vs & ~vs_q;
  wire line_end = ~vid_de | vid_hs;
  wire full     = (count == CNT_W'(FIFO_DEPTH));
  wire pop      = ce & m_tvalid & m_tready;
  wire push     = ce & hold_vld;
  wire wr_ok    = push & (~full | pop);
  wire drop     = push & full & ~pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q      <= 1'b0;
      sof_armed <= 1'b0;
      hold_vld  <= 1'b0;
      hold_sof  <= 1'b0;
      hold_pix  <= '0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      overflow  <= 1'b0;
    end else if (ce) begin
      vs_q <= vid_vs;
      if (vid_de) begin
        hold_vld  <= 1'b1;
        hold_pix  <= pix_pad;
        hold_sof  <= sof_armed | vs_edge;
        sof_armed <= 1'b0;
      end else begin
        hold_vld <= 1'b0;
        if (vs_edge) sof_armed <= 1'b1;
      end
      if (wr_ok) wr_ptr <= nxt(wr_ptr);
      if (pop)   rd_ptr <= nxt(rd_ptr);
      count <= count + CNT_W'(wr_ok) - CNT_W'(pop);
      if (drop) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= {hold_sof, line_end, hold_pix};
  end

  assign m_tvalid = (count != '0);
  assign {m_tuser, m_tlast, m_tdata} = mem[rd_ptr];

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !(m_tready && ce) |=> m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast)); // R6
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(FIFO_DEPTH)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R7
  AST_CE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(count) && $stable(sof_armed) && $stable(hold_vld) && $stable(vs_q) && $stable(overflow)); // R8
  AST_NO_TAKE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !m_tvalid && !push |=> !m_tvalid); // R1
endmodule

// File: tb/vid2axis_bridge_bench.sv
module vid2axis_bridge_bench;
  localparam int CW = 10, NC = 3, DEP = 4;
  localparam int LW = ((CW + 7) / 8) * 8;
  localparam int IW = CW * NC, OW = LW * NC;

  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0;
  logic [IW-1:0] vid_pix = '0;
  logic vid_de = 1'b0, vid_hs = 1'b0, vid_vs = 1'b0, m_tready = 1'b0;
  logic [OW-1:0] m_tdata;
  logic m_tvalid, m_tuser, m_tlast, overflow;

  always #2.5 clk = ~clk;

  vid2axis_bridge #(.COMP_W(CW), .NUM_COMP(NC), .FIFO_DEPTH(DEP)) u_vid2axis_bridge (
    .clk(clk), .rst_n(rst_n), .ce(ce), .vid_pix(vid_pix), .vid_de(vid_de),
    .vid_hs(vid_hs), .vid_vs(vid_vs), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
    .m_tready(m_tready), .m_tuser(m_tuser), .m_tlast(m_tlast), .overflow(overflow));

  int nchk = 0, nerr = 0;
  logic [OW+1:0] expq[$];
  logic [OW+1:0] stall_val;
  logic stall_pend = 1'b0;
  int rmode = 1;
  bit junk_en = 1'b0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] pad(input logic [IW-1:0] d);
    logic [OW-1:0] r = '0;
    for (int k = 0; k < NC; k++) r[k*LW +: CW] = d[k*CW +: CW];
    return r;
  endfunction

  task automatic step(input logic c, input logic de, input logic hs, input logic vs,
                      input logic [IW-1:0] d, input logic r);
    logic [OW+1:0] e;
    @(negedge clk);
    ce = c; vid_de = de; vid_hs = hs; vid_vs = vs; vid_pix = d; m_tready = r;
    if (stall_pend) chk("R6 held beat", {m_tvalid, m_tuser, m_tlast, m_tdata}, {1'b1, stall_val});
    stall_pend = 1'b0;
    if (m_tvalid && rst_n) begin
      if (r && c) begin
        if (expq.size() == 0) chk("R2 unexpected beat", 64'(m_tdata), 64'hDEAD);
        else begin
          e = expq.pop_front();
          chk("R2 R5 tdata", 64'(m_tdata), 64'(e[OW-1:0]));
          chk("R3 tuser", 64'(m_tuser), 64'(e[OW+1]));
          chk("R4 tlast", 64'(m_tlast), 64'(e[OW]));
        end
      end else begin
        stall_pend = 1'b1;
        stall_val = {m_tuser, m_tlast, m_tdata};
      end
    end
  endtask

  task automatic tick(input logic de, input logic hs, input logic vs, input logic [IW-1:0] d);
    logic r;
    if (junk_en)
      while ($urandom % 5 == 0)
        step(1'b0, 1'($urandom), 1'($urandom), 1'($urandom), IW'($urandom), 1'($urandom));
    r = (rmode == 2) ? 1'($urandom) : (rmode == 1);
    step(1'b1, de, hs, vs, d, r);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; stall_pend = 1'b0;
    #1;
    chk("R9 tvalid in reset", 64'(m_tvalid), 64'd0);
    chk("R9 overflow in reset", 64'(overflow), 64'd0);
    expq.delete();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic vpulse();
    tick(0, 0, 1, '0); tick(0, 0, 1, '0); tick(0, 0, 0, '0); tick(0, 0, 0, '0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, '0);
  endtask

  task automatic rand_frame();
    logic [IW-1:0] d;
    int nl, len;
    bit first = 1'b1;
    nl = 1 + int'($urandom % 3);
    rmode = 2; junk_en = 1'b1;
    vpulse();
    idle(int'($urandom % 4));
    for (int l = 0; l < nl; l++) begin
      len = 1 + int'($urandom % 3);
      rmode = 2; junk_en = 1'b1;
      for (int i = 0; i < len; i++) begin
        d = IW'($urandom);
        expq.push_back({first, (i == len - 1), pad(d)});
        first = 1'b0;
        tick(1, 0, 0, d);
      end
      tick(0, 1, 0, '0); tick(0, 0, 0, '0);
      rmode = 1; junk_en = 1'b0;
      idle(8);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [IW-1:0] p [7];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R9 tvalid at reset", 64'(m_tvalid), 64'd0);
    chk("R9 overflow at reset", 64'(overflow), 64'd0);
    rst_n = 1'b1;

    // R4: hsync on the next pixel closes the line; R3: early vsync arming
    rmode = 1; junk_en = 1'b0;
    vpulse(); idle(10);
    for (int i = 0; i < 3; i++) p[i] = IW'($urandom);
    expq.push_back({1'b1, 1'b0, pad(p[0])});
    expq.push_back({1'b0, 1'b1, pad(p[1])});
    expq.push_back({1'b0, 1'b1, pad(p[2])});
    tick(1, 0, 0, p[0]); tick(1, 0, 0, p[1]); tick(1, 1, 0, p[2]);
    idle(8);
    chk("R2 drained after hsync case", 64'(expq.size()), 64'd0);

    // R5 extremes: all-ones components keep pad bits zero
    p[0] = '1;
    expq.push_back({1'b0, 1'b1, pad(p[0])});
    tick(1, 0, 0, p[0]); idle(5);

    // R1 R8: sink ready but ce low holds the beat and ignores input
    rmode = 0;
    p[1] = IW'($urandom);
    expq.push_back({1'b0, 1'b1, pad(p[1])});
    tick(1, 0, 0, p[1]); tick(0, 0, 0, '0); tick(0, 0, 0, '0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 1'b1, IW'($urandom), 1'b1);
    chk("R8 junk ignored, one beat pending", 64'(m_tvalid), 64'd1);
    rmode = 1; idle(4);
    chk("R2 R8 no extra beats", 64'(expq.size()), 64'd0);

    // R7: overflow with a stalled sink
    rmode = 0;
    vpulse();
    for (int i = 0; i < 7; i++) p[i] = IW'($urandom);
    for (int i = 0; i < 4; i++) expq.push_back({(i == 0), 1'b0, pad(p[i])});
    for (int i = 0; i < 6; i++) tick(1, 0, 0, p[i]);
    chk("R7 no overflow before full drop", 64'(overflow), 64'd0);
    tick(1, 0, 0, p[6]);
    chk("R7 overflow on drop", 64'(overflow), 64'd1);
    idle(3);
    rmode = 1; idle(8);
    chk("R7 only depth beats delivered", 64'(expq.size()), 64'd0);
    chk("R7 overflow sticky", 64'(overflow), 64'd1);

    // R9: reset mid-stall cancels beats and armed start-of-frame
    rmode = 0;
    vpulse();
    tick(1, 0, 0, IW'($urandom)); tick(0, 0, 0, '0); tick(0, 0, 0, '0);
    vpulse();
    do_reset();
    chk("R9 overflow cleared", 64'(overflow), 64'd0);
    rmode = 1;
    for (int i = 0; i < 2; i++) p[i] = IW'($urandom);
    expq.push_back({1'b0, 1'b0, pad(p[0])});
    expq.push_back({1'b0, 1'b1, pad(p[1])});
    tick(1, 0, 0, p[0]); tick(1, 0, 0, p[1]); idle(6);
    chk("R9 no stale beats", 64'(expq.size()), 64'd0);

    // random frames with backpressure and clock-enable gaps
    for (int f = 0; f < 60; f++) rand_frame();
    rmode = 1; junk_en = 1'b0; idle(10);
    chk("R2 all pixels delivered", 64'(expq.size()), 64'd0);
    chk("R7 no overflow in random run", 64'(overflow), 64'd0);
    done = 1'b1;
    finish_run();
  end
endmodule